// File: doc/BRIEF.md
# Double-Buffered Timer Time-Base

This block is the counting core of a general-purpose timer. A prescaler divides the clock, and its output steps an up-counter. The counter runs from zero up to a reload limit and then wraps to zero. Neither the prescale ratio nor the reload limit is used straight from the value software writes. Each setting has a software-visible preload copy and a hidden working copy, called the shadow. Only the shadow drives the hardware.

The shadows take their preload values at an update event. An update event comes from a counter wrap or from a software request. Both shadows load on the same clock edge, so a new ratio and a new limit always take effect together. The reload setting has a preload-enable control. When it is clear, a reload write goes straight to its shadow. An update-disable control holds off all transfers while software writes several settings.

Software reaches the block through a single-cycle write port and a combinational read port. The block outputs the count, a one-cycle update pulse and a sticky update flag.

Top module: `tick_timebase`

## Requirements
- R1: After reset, the count, the update pulse and the update flag are all zero. Every register reads back zero, and both shadows are zero.
- R2: While running, the divider advances on every clock and the count steps once every (P+1) clocks, where P is the prescale shadow. The count goes 0..A, where A is the reload shadow, and then wraps to 0. So update events from wraps are (P+1)*(A+1) clocks apart.
- R3: Register map, selected by `addr`:
  - Address 0 is control. Bit 0 enables reload preload, bit 1 disables updates, bit 2 generates an update, and bit 3 runs the counter.
  - Address 1 is the prescale preload.
  - Address 2 is the reload preload.
  - Address 3 is status, with the update flag in bit 0.
  - Preloads read back as written. The generate bit always reads as 0.
- R4: A new prescale value never acts before an update event. The period in progress finishes with the old ratio.
- R5: With reload preload disabled, a reload write reaches the shadow on the same edge. The counter then wraps when it reaches the new value.
- R6: With reload preload enabled, a reload write leaves the shadow alone. The counter runs to the old limit, and the new value takes effect from that wrap.
- R7: While update-disable is set, the counter still wraps at the limit. No update pulse is produced, the flag does not set, and neither shadow loads.
- R8: Writing control with bit 2 set and bit 1 clear forces an update event. On that edge the count and the divider clear, and both shadows load, even with reload preload enabled.
- R9: Writing control with bits 2 and 1 both set clears the count and the divider. It produces no update pulse, sets no flag and loads no shadow.
- R10: `upd_o` is high for exactly the one cycle after each update event, and the count is 0 in that cycle. The flag sets together with the pulse and stays set. Writing 0 to status bit 0 clears it; writing 1 has no effect.
- R11: At an update event, both shadows load on the same edge. The next period uses both new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 2 | Register select for read and write |
| wdata | input | DW (16) | Write data |
| rdata | output | DW (16) | Read data for `addr`, combinational |
| count_o | output | CW (16) | Counter value |
| upd_o | output | 1 | Update event pulse, one cycle |
| flag_o | output | 1 | Sticky update flag |

## Verification
The bound checker watches, on every cycle, the rules that hold cycle by cycle:
- the count steps by at most one or returns to zero;
- a wrap with updates enabled produces the pulse;
- while update-disable is held, no pulse appears;
- a generate write clears the count;
- a direct reload write lands in the shadow on the next edge;
- the pulse coincides with a zero count and a set flag;
- the generate bit never reads back as one.

Whether a buffered prescale or reload value is held back for exactly one period only shows up over whole periods, so the bench's scenarios cover it. So do the joint switch of both settings, the exact (P+1)*(A+1) spacing across a sweep of small settings, and the suppressed load under update-disable.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_PSC  = 2'd1,
    A_ARR  = 2'd2,
    A_STAT = 2'd3
  } tb_addr_e;

  localparam int B_PRE  = 0;
  localparam int B_UDIS = 1;
  localparam int B_GEN  = 2;
  localparam int B_RUN  = 3;

  // clocks between update events caused by counter wraps
  function automatic int period_clocks(input int psc, input int arr);
    return (psc + 1) * (arr + 1);
  endfunction

  // next divider value: wraps when it meets the shadow ratio
  function automatic logic [15:0] div_next(input logic [15:0] cur, input logic [15:0] lim);
    return (cur == lim) ? 16'd0 : cur + 16'd1;
  endfunction
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] psc_sh,
  output logic          tick
);
  logic [PW-1:0] div_q;

  assign tick = run && !clr && (div_q == psc_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else if (run) div_q <= (div_q == psc_sh) ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] arr_sh,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  assign ovf = tick && (cnt == arr_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (ovf)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ovf,
  output logic          pre_en,
  output logic          udis,
  output logic          run,
  output logic          sw_gen,
  output logic          update_evt,
  output logic [PW-1:0] psc_sh,
  output logic [CW-1:0] arr_sh,
  output logic          upd_q,
  output logic          flag_q
);
  logic [PW-1:0] psc_pre;
  logic [CW-1:0] arr_pre;
  logic          wr_ctrl, wr_psc, wr_arr, wr_stat;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_psc  = wr_en && (addr == A_PSC);
  assign wr_arr  = wr_en && (addr == A_ARR);
  assign wr_stat = wr_en && (addr == A_STAT);

  assign sw_gen     = wr_ctrl && wdata[B_GEN];
  assign update_evt = (ovf && !udis) || (sw_gen && !wdata[B_UDIS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en  <= 1'b0;
      udis    <= 1'b0;
      run     <= 1'b0;
      psc_pre <= '0;
      arr_pre <= '0;
    end else begin
      if (wr_ctrl) begin
        pre_en <= wdata[B_PRE];
        udis   <= wdata[B_UDIS];
        run    <= wdata[B_RUN];
      end
      if (wr_psc) psc_pre <= wdata[PW-1:0];
      if (wr_arr) arr_pre <= wdata[CW-1:0];
    end
  end

  // shadows: joint load on update, direct reload write when preload is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_sh <= '0;
      arr_sh <= '0;
    end else begin
      if (update_evt) begin
        psc_sh <= psc_pre;
        arr_sh <= arr_pre;
      end
      if (wr_arr && !pre_en) arr_sh <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      upd_q <= update_evt;
      if (update_evt)                flag_q <= 1'b1;
      else if (wr_stat && !wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[B_PRE]  = pre_en;
        rdata[B_UDIS] = udis;
        rdata[B_RUN]  = run;
      end
      A_PSC:  rdata[PW-1:0] = psc_pre;
      A_ARR:  rdata[CW-1:0] = arr_pre;
      A_STAT: rdata[0] = flag_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count_o,
  output logic          upd_o,
  output logic          flag_o
);
  logic          ovf, tick, pre_en, udis, run, sw_gen, update_evt;
  logic [PW-1:0] psc_sh;
  logic [CW-1:0] arr_sh;

  tbase_regs #(.DW(DW), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ovf(ovf), .pre_en(pre_en), .udis(udis), .run(run),
    .sw_gen(sw_gen), .update_evt(update_evt), .psc_sh(psc_sh),
    .arr_sh(arr_sh), .upd_q(upd_o), .flag_q(flag_o)
  );

  tbase_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(sw_gen),
    .psc_sh(psc_sh), .tick(tick)
  );

  tbase_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(sw_gen),
    .arr_sh(arr_sh), .cnt(count_o), .ovf(ovf)
  );
endmodule

// File: rtl/tick_timebase_chk.sv
module tick_timebase_chk #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [CW-1:0] count_o,
  input logic          upd_o,
  input logic          flag_o,
  input logic          ovf,
  input logic          udis,
  input logic          pre_en,
  input logic [CW-1:0] arr_sh
);
  logic gen_wr;
  assign gen_wr = wr_en && (addr == 2'd0) && wdata[2];

  p_pulse_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (count_o == '0) && flag_o);

  p_wrap_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !udis) |=> upd_o);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == '0) || (count_o == $past(count_o)) ||
             (count_o == $past(count_o) + 1'b1));

  p_udis_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (udis && !gen_wr) |=> !upd_o);

  p_gen_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wr |=> count_o == '0);

  p_direct_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !pre_en) |=> arr_sh == $past(wdata[CW-1:0]));

  always_comb begin
    if (rst_n && addr == 2'd0) p_gen_reads0_r3: assert (!rdata[2]);
  end
endmodule

bind tick_timebase tick_timebase_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .count_o(count_o), .upd_o(upd_o), .flag_o(flag_o),
  .ovf(ovf), .udis(udis), .pre_en(pre_en), .arr_sh(arr_sh)
);

// File: tb/tick_timebase_test.sv
`timescale 1ns/1ps
module tick_timebase_test;
  localparam logic [15:0] PRE = 16'h1, UDIS = 16'h2, GEN = 16'h4, RUN = 16'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count_o;
  logic        upd_o, flag_o;
  int checks = 0, errors = 0;

  tick_timebase uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count_o(count_o), .upd_o(upd_o), .flag_o(flag_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata; addr = 2'd0;
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_o && n < 5000);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int g, cv, mx;
    bit wrapped, pulsed;
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(count_o == 0 && !upd_o && !flag_o, "R1 outputs", count_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check(d == 0, "R1 readback", d, 0);
    end

    // R2 period sweep, preload off
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 5; a++) begin
        wr(2'd1, p[15:0]);
        wr(2'd2, a[15:0]);
        wr(2'd0, RUN | GEN);
        check(upd_o && count_o == 0, "R8 gen pulse", upd_o, 1);
        gap(g); check(g == (p + 1) * (a + 1), "R2 period", g, (p + 1) * (a + 1));
        gap(g); check(g == (p + 1) * (a + 1), "R2 period", g, (p + 1) * (a + 1));
      end
    end

    // R4 prescale buffered: P=1,A=3 then write P=2 mid-period
    wr(2'd1, 16'd1); wr(2'd2, 16'd3); wr(2'd0, RUN | GEN);
    wr(2'd1, 16'd2);
    gap(g); check(g == 6, "R4 old ratio kept", g, 6);
    gap(g); check(g == 12, "R4 new ratio at update", g, 12);
    rd(2'd1, d); check(d == 2, "R3 prescale readback", d, 2);

    // R5 direct reload with preload off
    wr(2'd1, 16'd0); wr(2'd2, 16'd20); wr(2'd0, RUN | GEN);
    wr(2'd2, 16'd10);
    cv = count_o;
    gap(g); check(g == 10 - cv + 1, "R5 immediate reload", g, 10 - cv + 1);
    gap(g); check(g == 11, "R5 period after", g, 11);

    // R6 / R11 deferred reload, joint load with prescale
    wr(2'd2, 16'd20); wr(2'd0, RUN | PRE | GEN);
    wr(2'd2, 16'd10); wr(2'd1, 16'd1);
    cv = count_o;
    gap(g); check(g == 20 - cv + 1, "R6 old limit kept", g, 20 - cv + 1);
    gap(g); check(g == 22, "R11 both settings switch together", g, 22);
    rd(2'd2, d); check(d == 10, "R3 reload readback", d, 10);

    // R7 update disable
    wr(2'd0, RUN | PRE | UDIS);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd3); wr(2'd1, 16'd0);
    mx = 0; wrapped = 0; pulsed = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (count_o > mx) mx = count_o;
      if (count_o == 0) wrapped = 1;
      if (upd_o) pulsed = 1;
    end
    check(!pulsed, "R7 no pulse", pulsed, 0);
    check(!flag_o, "R7 no flag", flag_o, 0);
    check(mx == 10, "R7 shadows held", mx, 10);
    check(wrapped, "R7 counter still wraps", wrapped, 1);

    // R9 generate while disabled
    wr(2'd0, RUN | PRE | UDIS | GEN);
    check(count_o == 0 && !upd_o, "R9 clear without pulse", upd_o, 0);
    check(!flag_o, "R9 no flag", flag_o, 0);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (count_o > mx) mx = count_o;
    end
    check(mx == 10, "R9 shadows not loaded", mx, 10);
    rd(2'd0, d); check(d == (RUN | PRE | UDIS), "R3 ctrl readback gen 0", d, RUN | PRE | UDIS);

    // R8 forced update applies buffered values
    wr(2'd0, RUN | PRE | GEN);
    check(upd_o && count_o == 0 && flag_o, "R8 forced update", upd_o, 1);
    @(negedge clk); check(!upd_o, "R10 single-cycle pulse", upd_o, 0);
    gap(g); check(g == 3, "R8 buffered limit applied", g, 3);
    gap(g); check(g == 4, "R8 period", g, 4);

    // R10 sticky flag
    wr(2'd0, PRE);
    repeat (4) @(negedge clk);
    check(flag_o, "R10 flag sticky", flag_o, 1);
    wr(2'd3, 16'd1);
    rd(2'd3, d); check(d == 1, "R10 write 1 no effect", d, 1);
    wr(2'd3, 16'd0);
    check(!flag_o, "R10 write 0 clears", flag_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule